// File: doc/BRIEF.md
# Configuration command request decoder

This block sits on a simple memory-mapped register bus and gives software three words for system configuration: a data word, a control word and a status word. Writing the control word launches a command. The block keeps the written word with two bits forced to zero and marks the command complete. It then compares the kept word with two known command codes. One code produces a one-cycle power-off request and the other produces a one-cycle restart request. Any other word also sets an error bit in the status word.

Software can clear or rewrite the two status bits. The data word is plain storage. A build-time parameter can remove the register function entirely. In that case the three offsets read as zero, ignore writes, and raise a bad-address indication for each access that hits them. Reads are combinational within the access cycle. Register updates and request pulses take effect at the clock edge that ends a write cycle.

Top module: `cfg_cmd_decoder`

## Requirements
- R1: After reset all three registers read zero and both request outputs are low.
- R2: The data register at offset 0xA0 stores all 32 written bits and returns them on read. Writing it changes neither the status register nor the request outputs.
- R3: A write to the control register at offset 0xA4 stores the written data with bits 19 and 18 cleared. Reads of 0xA4 return that stored value.
- R4: Every control write sets status bit 0 (complete), visible from the next cycle.
- R5: A control write whose masked value equals 0xC0800000 drives shutdown_req_o high for exactly the one cycle after the write edge and leaves status at 1.
- R6: A control write whose masked value equals 0xC0900000 drives reboot_req_o high for exactly the one cycle after the write edge and leaves status at 1.
- R7: A control write with any other masked value sets status to 3 (bit 1 = error, bit 0 = complete) and raises no request.
- R8: A write to the status register at offset 0xA8 stores only data bits 1:0. Reads return them in bits 1:0 with all other bits zero.
- R9: A read to any other offset, or any cycle with rd_en_i low, returns zero on rdata_o. A write to any other offset changes no register.
- R10: With ENABLE = 0, the three offsets read zero and writes have no effect. bad_addr_o is high in every cycle that reads or writes one of them. No request is ever raised.
- R11: The two request outputs are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for this cycle |
| rd_en_i | input | 1 | Read strobe for this cycle |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, zero when not reading a mapped register |
| shutdown_req_o | output | 1 | One-cycle power-off request |
| reboot_req_o | output | 1 | One-cycle restart request |
| bad_addr_o | output | 1 | Access hit an offset of the disabled block |

## Verification
A wrong internal state has two visible effects. A bad masked control word or a wrong command match shows up on the request pins in the cycle right after the write edge. A wrong stored value or status bit shows up only on the next read of that offset. For this reason the stimulus reads back every register after each kind of write, and it pairs writes with the cycle that follows them. The masked bits 19:18 are probed with a command code that matches only after masking. A second instance with the block disabled is driven with the same stimulus to check the unmapped behaviour.

// File: rtl/cfg_cmd_pkg.sv
package cfg_cmd_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  localparam int unsigned N_REGS = 3;
  localparam int unsigned OFF_DATA = 32'hA0;
  localparam int unsigned OFF_CTRL = 32'hA4;
  localparam int unsigned OFF_STAT = 32'hA8;

  localparam int unsigned SEL_DATA = 0;
  localparam int unsigned SEL_CTRL = 1;
  localparam int unsigned SEL_STAT = 2;

  localparam word_t CTRL_KEEP    = ~(word_t'(3) << 18);
  localparam word_t CMD_SHUTDOWN = 32'hC080_0000;
  localparam word_t CMD_REBOOT   = 32'hC090_0000;

  localparam int unsigned STAT_W = 2;
  localparam logic [STAT_W-1:0] STAT_DONE = 2'b01;
  localparam logic [STAT_W-1:0] STAT_ERR  = 2'b11;

  typedef enum logic [1:0] {
    CMD_UNKNOWN = 2'd0,
    CMD_POWEROFF = 2'd1,
    CMD_RESTART = 2'd2
  } cmd_kind_e;
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfg_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [N_REGS-1:0]  sel_o
);
  localparam int unsigned OFFS [N_REGS] = '{OFF_DATA, OFF_CTRL, OFF_STAT};

  for (genvar i = 0; i < N_REGS; i++) begin : g_sel
    assign sel_o[i] = (addr_i == ADDR_W'(OFFS[i]));
  end
endmodule

// File: rtl/cfg_cmd_classify.sv
module cfg_cmd_classify
  import cfg_cmd_pkg::*;
(
  input  word_t     ctrl_i,
  output cmd_kind_e kind_o
);
  always_comb begin
    if (ctrl_i == CMD_SHUTDOWN)    kind_o = CMD_POWEROFF;
    else if (ctrl_i == CMD_REBOOT) kind_o = CMD_RESTART;
    else                           kind_o = CMD_UNKNOWN;
  end
endmodule

// File: rtl/cfg_cmd_regs.sv
module cfg_cmd_regs
  import cfg_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_data_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_stat_i,
  input  word_t             wdata_i,
  output word_t             data_o,
  output word_t             ctrl_o,
  output logic [STAT_W-1:0] stat_o,
  output logic              shutdown_o,
  output logic              reboot_o
);
  word_t     masked;
  cmd_kind_e kind;

  assign masked = wdata_i & CTRL_KEEP;

  cfg_cmd_classify u_classify (
    .ctrl_i (masked),
    .kind_o (kind)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o     <= '0;
      ctrl_o     <= '0;
      stat_o     <= '0;
      shutdown_o <= 1'b0;
      reboot_o   <= 1'b0;
    end else begin
      shutdown_o <= wr_ctrl_i && (kind == CMD_POWEROFF);
      reboot_o   <= wr_ctrl_i && (kind == CMD_RESTART);
      if (wr_data_i) data_o <= wdata_i;
      if (wr_ctrl_i) begin
        ctrl_o <= masked;
        stat_o <= (kind == CMD_UNKNOWN) ? STAT_ERR : STAT_DONE;
      end else if (wr_stat_i) begin
        stat_o <= wdata_i[STAT_W-1:0];
      end
    end
  end

  assert_ctrl_masked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl_i |=> ctrl_o == ($past(wdata_i) & CTRL_KEEP));

  assert_done_after_cmd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl_i |=> stat_o[0]);

  assert_shutdown_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> $past(wr_ctrl_i && ((wdata_i & CTRL_KEEP) == CMD_SHUTDOWN)));

  assert_reboot_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reboot_o |-> $past(wr_ctrl_i && ((wdata_i & CTRL_KEEP) == CMD_REBOOT)));

  assert_unknown_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl_i && (masked != CMD_SHUTDOWN) && (masked != CMD_REBOOT)) |=> stat_o == STAT_ERR);

  assert_stat_low_bits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat_i && !wr_ctrl_i) |=> stat_o == $past(wdata_i[STAT_W-1:0]));

  assert_one_request_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shutdown_o && reboot_o));
endmodule

// File: rtl/cfg_cmd_decoder.sv
module cfg_cmd_decoder
  import cfg_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter bit          ENABLE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              shutdown_req_o,
  output logic              reboot_req_o,
  output logic              bad_addr_o
);
  logic [N_REGS-1:0] sel;

  cfg_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  if (ENABLE) begin : g_on
    word_t             data_q, ctrl_q;
    logic [STAT_W-1:0] stat_q;

    cfg_cmd_regs u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_data_i  (wr_en_i && sel[SEL_DATA]),
      .wr_ctrl_i  (wr_en_i && sel[SEL_CTRL]),
      .wr_stat_i  (wr_en_i && sel[SEL_STAT]),
      .wdata_i    (wdata_i),
      .data_o     (data_q),
      .ctrl_o     (ctrl_q),
      .stat_o     (stat_q),
      .shutdown_o (shutdown_req_o),
      .reboot_o   (reboot_req_o)
    );

    always_comb begin
      rdata_o = '0;
      if (rd_en_i) begin
        if (sel[SEL_DATA])      rdata_o = data_q;
        else if (sel[SEL_CTRL]) rdata_o = ctrl_q;
        else if (sel[SEL_STAT]) rdata_o = {{(WORD_W-STAT_W){1'b0}}, stat_q};
      end
    end
    assign bad_addr_o = 1'b0;
  end else begin : g_off
    assign rdata_o        = '0;
    assign shutdown_req_o = 1'b0;
    assign reboot_req_o   = 1'b0;
    assign bad_addr_o     = (rd_en_i || wr_en_i) && (|sel);
  end
endmodule

// File: tb/cfg_cmd_decoder_test.sv
`timescale 1ns/1ps
module cfg_cmd_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_off;
  logic        shut, reboot, bad, shut_off, reboot_off, bad_off;

  int vectors = 0, miscompares = 0;

  // reference state
  logic [31:0] m_data = 0, m_ctrl = 0;
  logic [1:0]  m_stat = 0;
  bit          m_shut = 0, m_reboot = 0;

  always #2.5 clk = ~clk;

  cfg_cmd_decoder #(.ADDR_W(12), .ENABLE(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .shutdown_req_o(shut), .reboot_req_o(reboot), .bad_addr_o(bad));

  cfg_cmd_decoder #(.ADDR_W(12), .ENABLE(1'b0)) uut_off (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_off),
    .shutdown_req_o(shut_off), .reboot_req_o(reboot_off), .bad_addr_o(bad_off));

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one bus cycle: drive, compare against model, advance model at the edge
  task automatic step(string tag, bit wr, bit rd, logic [11:0] a, logic [31:0] d);
    logic [31:0] exp_rd;
    bit hit;
    wr_en = wr; rd_en = rd; addr = a; wdata = d;
    #1;
    hit = (a == 12'hA0) || (a == 12'hA4) || (a == 12'hA8);
    exp_rd = 0;
    if (rd) begin
      if (a == 12'hA0)      exp_rd = m_data;
      else if (a == 12'hA4) exp_rd = m_ctrl;
      else if (a == 12'hA8) exp_rd = {30'b0, m_stat};
    end
    check(tag, "rdata", rdata, exp_rd);
    check(tag, "shutdown", {31'b0, shut}, {31'b0, m_shut});
    check(tag, "reboot", {31'b0, reboot}, {31'b0, m_reboot});
    check(tag, "bad_addr", {31'b0, bad}, 0);
    check("R10", "off rdata", rdata_off, 0);
    check("R10", "off requests", {30'b0, shut_off, reboot_off}, 0);
    check("R10", "off bad_addr", {31'b0, bad_off}, {31'b0, (rd || wr) && hit});
    @(posedge clk);
    m_shut = 0; m_reboot = 0;
    if (wr) begin
      if (a == 12'hA0) m_data = d;
      else if (a == 12'hA4) begin
        m_ctrl = d & 32'hFFF3_FFFF;
        m_shut   = (m_ctrl == 32'hC080_0000);
        m_reboot = (m_ctrl == 32'hC090_0000);
        m_stat = (m_shut || m_reboot) ? 2'd1 : 2'd3;
      end else if (a == 12'hA8) m_stat = d[1:0];
    end
    @(negedge clk);
  endtask

  initial begin
    #200000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    step("R1", 0, 1, 12'hA0, 0);
    step("R1", 0, 1, 12'hA4, 0);
    step("R1", 0, 1, 12'hA8, 0);
    // R2 data storage, no side effects
    step("R2", 1, 0, 12'hA0, 32'hDEAD_BEEF);
    step("R2", 0, 1, 12'hA0, 0);
    step("R2", 0, 1, 12'hA8, 0);
    // R3 R4 R7 unknown command, masked bits
    step("R3", 1, 0, 12'hA4, 32'hFFFF_FFFF);
    step("R7", 0, 1, 12'hA8, 0);
    step("R3", 0, 1, 12'hA4, 0);
    // R8 status rewrite
    step("R8", 1, 0, 12'hA8, 32'h0);
    step("R8", 0, 1, 12'hA8, 0);
    step("R8", 1, 0, 12'hA8, 32'hFFFF_FFFE);
    step("R8", 0, 1, 12'hA8, 0);
    // R5 shutdown, then again with masked bits set, read in pulse cycle
    step("R5", 1, 0, 12'hA4, 32'hC080_0000);
    step("R4", 0, 1, 12'hA8, 0);
    step("R5", 1, 1, 12'hA4, 32'hC08C_0000);
    step("R5", 0, 1, 12'hA4, 0);
    // R6 reboot back-to-back with shutdown, then unknown near-miss
    step("R6", 1, 0, 12'hA4, 32'hC090_0000);
    step("R11", 1, 0, 12'hA4, 32'hC080_0000);
    step("R6", 1, 0, 12'hA4, 32'hC094_0000);
    step("R7", 1, 0, 12'hA4, 32'hC090_0001);
    step("R7", 0, 1, 12'hA8, 0);
    step("R4", 1, 0, 12'hA4, 32'hC090_0000);
    step("R4", 0, 1, 12'hA8, 0);
    // R9 unmapped offsets and idle reads
    step("R9", 1, 0, 12'h1A0, 32'h1234_5678);
    step("R9", 1, 0, 12'hA2, 32'h1234_5678);
    step("R9", 0, 1, 12'h1A0, 0);
    step("R9", 0, 0, 12'hA0, 0);
    step("R9", 0, 1, 12'hA0, 0);
    step("R9", 0, 1, 12'hA4, 0);
    step("R9", 0, 1, 12'hA8, 0);
    step("R2", 0, 0, 12'h000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule